// File: doc/BRIEF.md
# Vector Register Slide Unit

This block builds one N-lane vector from two N-lane source registers and a signed 16-bit slide amount. The two sources are joined end to end, with the second source (`src1`) forming the low half and the first source (`src0`) the high half. An N-lane window is then cut from that joined vector, starting at lane N minus the amount. The result is `src0` moved up by the amount, with the vacated low lanes filled from the top of `src1`. A mode pin selects a second form in which `src1` plays no part and the vacated lanes are filled with zero. This is a plain zero-fill shift toward higher lane numbers. Typical uses are sliding-window arithmetic and shift-register style data reuse across consecutive vectors.

Operands enter on a valid/ready handshake, and the block computes the window in the cycle an operand set is accepted. The result is held in a single output register. An operand set is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result appears with `out_valid` one cycle later and stays stable until the consumer takes it with `out_ready`. While an unconsumed result is held and `out_ready` is low, `in_ready` is low and the producer must hold its operands. A new operand set may be accepted in the same cycle that the held result is consumed, so the block sustains one result per cycle.

Top module: `vslide_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `mode`=0 (two-source) and an amount a in 1..N-1, result lane i (lane 0 in bits WIDTH-1:0) is `src0` lane i-a for i >= a and `src1` lane N-a+i for i < a.
- R3: With `mode`=1 (zero fill), result lane i is `src0` lane i-a for i >= a and zero for i < a; `src1` has no effect on the result.
- R4: An amount of 0 returns `src0` unchanged in both modes.
- R5: An amount of N or more (as a positive two's complement value) returns `src1` in lane order with `mode`=0 and all zeros with `mode`=1.
- R6: A negative amount (bit 15 set, two's complement) behaves as an amount of 0.
- R7: The result of an accepted operand set is on `result` with `out_valid` high at the first clock edge after acceptance.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `result` stays unchanged, and `in_ready` is 0, so no new operand set is accepted.
- R9: `in_ready` is 1 whenever `out_ready` is 1; a held result and a new operand set are exchanged on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Block can accept an operand set |
| mode | input | 1 | 0 = fill from `src1`, 1 = fill with zero |
| amount | input | 16 | Signed slide amount, two's complement |
| src0 | input | LANES*WIDTH | Source moved up into the result |
| src1 | input | LANES*WIDTH | Fill source for the low lanes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | LANES*WIDTH | Extracted window |

## Verification
Every result is due one cycle after its operands are accepted. The bench drives each operand set just after a rising edge and confirms acceptance by sampling `in_ready` at the falling edge. At the falling edge after the accepting edge, it checks `out_valid` and `result` against a reference computed from the requirements. A scoreboard queue receives each expected window when its operands are accepted. A monitor, sampling at falling edges, pops and compares the queue on every cycle where `out_valid` and `out_ready` are both high, so results that are held under back-pressure are compared only once, when they are handed over. In the back-pressure phase, `in_ready`, `out_valid` and `result` are checked on each stalled cycle, and then on the exchange cycle where the held result leaves and the next operand set enters.

// File: rtl/vslide_pkg.sv
package vslide_pkg;

  typedef enum logic {
    SLIDE_TWO  = 1'b0,
    SLIDE_ZERO = 1'b1
  } slide_mode_e;

  localparam int AMOUNT_BITS = 16;

endpackage

// File: rtl/vslide_amt_norm.sv
module vslide_amt_norm #(
  parameter int LANES = 8,
  parameter int SEL_W = $clog2(LANES + 1)
) (
  input  logic [vslide_pkg::AMOUNT_BITS-1:0] amt_in,
  output logic [SEL_W-1:0]                   amt_out
);

  int amt_s;

  always_comb begin
    amt_s = int'($signed(amt_in));
    if (amt_s < 0) begin
      amt_out = '0;
    end else if (amt_s >= LANES) begin
      amt_out = SEL_W'(LANES);
    end else begin
      amt_out = SEL_W'(amt_s);
    end
  end

endmodule

// File: rtl/vslide_lane_mux.sv
module vslide_lane_mux
  import vslide_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIDTH = 32,
  parameter int SEL_W = $clog2(LANES + 1),
  localparam int DW   = LANES * WIDTH
) (
  input  slide_mode_e      mode,
  input  logic [SEL_W-1:0] amt,
  input  logic [DW-1:0]    src0,
  input  logic [DW-1:0]    src1,
  output logic [DW-1:0]    res
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WIDTH-1:0] lane_v;

    always_comb begin
      lane_v = '0;
      for (int k = 0; k <= LANES; k++) begin
        if (int'(amt) == k) begin
          if (g >= k) begin
            lane_v = src0[(g - k) * WIDTH +: WIDTH];
          end else if (mode == SLIDE_TWO) begin
            lane_v = src1[(LANES - k + g) * WIDTH +: WIDTH];
          end
        end
      end
    end

    assign res[g * WIDTH +: WIDTH] = lane_v;
  end

endmodule

// File: rtl/vslide_out_reg.sv
module vslide_out_reg #(
  parameter int DW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_valid,
  input  logic [DW-1:0] load_data,
  output logic          load_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  logic take;

  assign load_ready = !out_valid || out_ready;
  assign take       = load_valid && load_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: rtl/vslide_unit.sv
module vslide_unit
  import vslide_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIDTH = 32,
  localparam int DW    = LANES * WIDTH,
  localparam int SEL_W = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          mode,
  input  logic [15:0]   amount,
  input  logic [DW-1:0] src0,
  input  logic [DW-1:0] src1,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] result
);

  slide_mode_e      mode_e;
  logic [SEL_W-1:0] amt_n;
  logic [DW-1:0]    window;

  assign mode_e = slide_mode_e'(mode);

  vslide_amt_norm #(
    .LANES (LANES),
    .SEL_W (SEL_W)
  ) i_norm (
    .amt_in  (amount),
    .amt_out (amt_n)
  );

  vslide_lane_mux #(
    .LANES (LANES),
    .WIDTH (WIDTH),
    .SEL_W (SEL_W)
  ) i_mux (
    .mode (mode_e),
    .amt  (amt_n),
    .src0 (src0),
    .src1 (src1),
    .res  (window)
  );

  vslide_out_reg #(
    .DW (DW)
  ) i_oreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (in_valid),
    .load_data  (window),
    .load_ready (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (result)
  );

  logic acc;
  assign acc = in_valid && in_ready;

  // R4
  zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && amount == 16'd0 |=> result == $past(src0));

  // R6
  neg_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && amount[15] |=> result == $past(src0));

  // R5
  far_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !mode && !amount[15] && int'(amount) >= LANES
      |=> result == $past(src1));

  // R5
  far_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode && !amount[15] && int'(amount) >= LANES
      |=> result == '0);

endmodule

// File: tb/test_vslide_unit.sv
module test_vslide_unit;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 8;
  localparam int WIDTH      = 32;
  localparam int DW         = LANES * WIDTH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          mode = 1'b0;
  logic [15:0]   amount = '0;
  logic [DW-1:0] src0 = '0;
  logic [DW-1:0] src1 = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] result;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  vslide_unit #(.LANES(LANES), .WIDTH(WIDTH)) i_vslide_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .mode      (mode),
    .amount    (amount),
    .src0      (src0),
    .src1      (src1),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result)
  );

  function automatic logic [DW-1:0] ref_window(logic m, logic [15:0] a,
                                               logic [DW-1:0] s0, logic [DW-1:0] s1);
    logic [DW-1:0] r;
    int sh;
    r  = '0;
    sh = int'($signed(a));
    if (sh < 0) sh = 0;
    if (sh > LANES) sh = LANES;
    for (int i = 0; i < LANES; i++) begin
      if (i >= sh) r[i * WIDTH +: WIDTH] = s0[(i - sh) * WIDTH +: WIDTH];
      else if (!m) r[i * WIDTH +: WIDTH] = s1[(LANES - sh + i) * WIDTH +: WIDTH];
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] make_vec(logic [7:0] tagb, bit rnd);
    logic [DW-1:0] v;
    for (int i = 0; i < LANES; i++) begin
      if (rnd) v[i * WIDTH +: WIDTH] = $urandom;
      else v[i * WIDTH +: WIDTH] = {tagb, 16'h0000, 8'(i)};
    end
    return v;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Drives one operand set, waits for acceptance, pushes the expected window
  // and checks the one-cycle latency (R7).
  task automatic send(logic m, logic [15:0] a, logic [DW-1:0] s0,
                      logic [DW-1:0] s1, string req);
    logic [DW-1:0] e;
    @(posedge clk);
    #1;
    in_valid = 1'b1;
    mode     = m;
    amount   = a;
    src0     = s0;
    src1     = s1;
    e        = ref_window(m, a, s0, s1);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(req);
    #1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 out_valid", {{(DW-1){1'b0}}, out_valid}, {{(DW-1){1'b0}}, 1'b1});
    check("R7 result", result, e);
  endtask

  // Scoreboard monitor: compares each handed-over result.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R7: unexpected result %h expected none", result);
        end else begin
          check(tag_q.pop_front(), result, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] a0, a1, b0, b1, r0, r1, ea, eb;
    a0 = make_vec(8'hA0, 1'b0);
    a1 = make_vec(8'hB0, 1'b0);
    b1 = make_vec(8'hC0, 1'b0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 out_valid", {{(DW-1){1'b0}}, out_valid}, '0);
    check("R1 in_ready", {{(DW-1){1'b0}}, in_ready}, {{(DW-1){1'b0}}, 1'b1});

    send(1'b0, 16'd0, a0, a1, "R4 two-source amt 0");
    send(1'b1, 16'd0, a0, a1, "R4 zero-fill amt 0");
    send(1'b0, 16'd1, a0, a1, "R2 amt 1");
    send(1'b0, 16'd3, a0, a1, "R2 amt 3");
    send(1'b0, 16'd7, a0, a1, "R2 amt 7");
    send(1'b1, 16'd2, a0, a1, "R3 amt 2");
    send(1'b1, 16'd5, a0, a1, "R3 amt 5");
    send(1'b1, 16'd5, a0, b1, "R3 src1 ignored");
    send(1'b0, 16'd8, a0, a1, "R5 two-source amt N");
    send(1'b0, 16'd100, a0, a1, "R5 two-source amt 100");
    send(1'b0, 16'h7FFF, a0, a1, "R5 two-source amt max");
    send(1'b1, 16'd8, a0, a1, "R5 zero-fill amt N");
    send(1'b1, 16'd300, a0, a1, "R5 zero-fill amt 300");
    send(1'b0, 16'hFFFF, a0, a1, "R6 amt -1");
    send(1'b1, 16'h8000, a0, a1, "R6 amt min");
    for (int n = 0; n < 12; n++) begin
      r0 = make_vec(8'h00, 1'b1);
      r1 = make_vec(8'h00, 1'b1);
      send(1'(n % 2), 16'(n % 9), r0, r1, (n % 2) ? "R3 random" : "R2 random");
    end

    // Back-pressure: hold one result, offer the next operand set.
    @(posedge clk);
    #1;
    out_ready = 1'b0;
    b0 = make_vec(8'hD0, 1'b0);
    send(1'b0, 16'd2, a0, a1, "R8 held item");
    ea = ref_window(1'b0, 16'd2, a0, a1);
    eb = ref_window(1'b1, 16'd4, b0, a1);
    @(posedge clk);
    #1;
    in_valid = 1'b1;
    mode     = 1'b1;
    amount   = 16'd4;
    src0     = b0;
    src1     = a1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R8 in_ready low", {{(DW-1){1'b0}}, in_ready}, '0);
      check("R8 out_valid held", {{(DW-1){1'b0}}, out_valid}, {{(DW-1){1'b0}}, 1'b1});
      check("R8 result held", result, ea);
    end
    @(posedge clk);
    #1;
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 in_ready with out_ready", {{(DW-1){1'b0}}, in_ready}, {{(DW-1){1'b0}}, 1'b1});
    @(posedge clk);
    exp_q.push_back(eb);
    tag_q.push_back("R9 exchanged item");
    #1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 next result", result, eb);

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7: pending results got %0d expected 0", exp_q.size());
    end
    summary();
  end

endmodule